// File: doc/BRIEF.md
# Debug Trigger Output Stage

This block sits between a cross-trigger channel matrix and a processor core. It turns a nine-bit request vector into nine trigger outputs. Output 0 asks the core to halt into debug state, output 7 asks it to resume, and output 8 is an active-low interrupt line. Outputs 1 to 6 can each be switched between level pass-through and single-cycle rising-edge pulses. The halt request and the interrupt are sticky: once set, they hold until software writes an acknowledge. In a compatibility mode, the core's debug-state indication clears the halt request instead of software.

The block also conditions seven status lines from the core into active-high trigger input events for the matrix. A simple register write port sets the edge-enable bits, issues acknowledges and selects the mode.

Top module: `dbg_trig_out_stage`

## Requirements
- R1: After reset, outputs 0 to 7 are low, `irq_no` is high, every edge-enable bit is 0 and default mode is selected.
- R2: With its edge-enable bit at 0, each of outputs 1 to 6 equals its request bit in the same cycle. Output 7 always equals `req_i[7]` in the same cycle.
- R3: A write with `wr_sel_i`=0 loads `wr_data_i[5:0]` as the edge-enable bits. Bit k controls output k+1. When that bit is enabled, the output is high only in a cycle where the request is 1 and was 0 in the previous cycle.
- R4: `req_i[0]` set in a cycle drives `trig_o[0]` high from the next cycle on. `req_i[8]` does the same for the interrupt. Each stays set until it is cleared.
- R5: A write with `wr_sel_i`=1 is an acknowledge. Data bit 0 clears output 0 and data bit 8 clears the interrupt, effective the next cycle. A data bit at 0 has no effect. Nothing is stored.
- R6: When an acknowledge and a new request for the same sticky output fall in the same cycle, the request wins and the output stays asserted.
- R7: `irq_no` is low exactly while the sticky interrupt trigger is set.
- R8: A write with `wr_sel_i`=2 sets compatibility mode from `wr_data_i[0]`. In that mode, output 0 clears the cycle after `dbg_state_i` is high, and acknowledge bit 0 is ignored. The interrupt still needs an acknowledge.
- R9: `trig_in_o[0]` equals `dbg_entry_i` in default mode and `dbg_state_i` in compatibility mode.
- R10: `trig_in_o[1]` is the inverse of `pmu_irq_ni`. `trig_in_o[3:2]` equal `perf_out_i[1:0]`, `trig_in_o[4]` equals `comm_rx_full_i`, `trig_in_o[5]` equals `comm_tx_empty_i` and `trig_in_o[6]` equals `trace_trig_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 edge enables, 1 acknowledge, 2 mode, 3 none |
| wr_data_i | input | 9 | Write data |
| req_i | input | 9 | Trigger requests from the channel matrix |
| dbg_entry_i | input | 1 | Pulse on debug-state entry |
| dbg_state_i | input | 1 | High while the core is in debug state |
| pmu_irq_ni | input | 1 | Performance monitor interrupt, active low |
| perf_out_i | input | 2 | Trace unit external outputs |
| comm_rx_full_i | input | 1 | Debug receive channel full |
| comm_tx_empty_i | input | 1 | Debug transmit channel empty |
| trace_trig_i | input | 1 | Trace unit trigger |
| trig_in_o | output | 7 | Conditioned trigger input events |
| trig_o | output | 8 | Trigger outputs 0 to 7 |
| irq_no | output | 1 | Interrupt trigger output 8, active low |

## Verification
The bench targets an acknowledge that lands in the same cycle as a fresh request. A design that lets the clear win drops a halt or an interrupt that software never saw. Acknowledge words with the sticky bits at zero must leave both outputs alone; a design that decodes the whole word or stores the acknowledge would clear them or keep clearing them. In compatibility mode, the bench checks that acknowledge bit 0 is ignored and that debug state clears the halt. It also toggles edge enables while requests are held high, so a design that drops its request history, or pulses on levels or falling edges, gives a visible mismatch.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int unsigned NUM_OUT  = 9;
  localparam int unsigned NUM_EDGE = 6;
  localparam int unsigned NUM_IN   = 7;
  localparam int unsigned HALT_IDX = 0;
  localparam int unsigned RUN_IDX  = 7;
  localparam int unsigned IRQ_IDX  = NUM_OUT - 1;

  typedef enum logic [1:0] {
    SEL_EDGE = 2'd0,
    SEL_ACK  = 2'd1,
    SEL_MODE = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/dbg_trig_edge.sv
module dbg_trig_edge #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] req_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= req_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign out_o[i] = en_i[i] ? (req_i[i] & ~hist_q[i]) : req_i[i];

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[i] && out_o[i]) |=> !(en_i[i] && out_o[i])); // R3
  end
endmodule

// File: rtl/dbg_trig_sticky.sv
module dbg_trig_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= set_i | (q_q & ~clr_i);
  end

  assign q_o = q_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o); // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o); // R4
endmodule

// File: rtl/dbg_trig_in_cond.sv
module dbg_trig_in_cond
  import dbg_trig_pkg::*;
(
  input  logic              compat_i,
  input  logic              dbg_entry_i,
  input  logic              dbg_state_i,
  input  logic              pmu_irq_ni,
  input  logic [1:0]        perf_out_i,
  input  logic              comm_rx_full_i,
  input  logic              comm_tx_empty_i,
  input  logic              trace_trig_i,
  output logic [NUM_IN-1:0] ev_o
);
  always_comb begin
    ev_o[0]   = compat_i ? dbg_state_i : dbg_entry_i;
    ev_o[1]   = ~pmu_irq_ni;
    ev_o[3:2] = perf_out_i;
    ev_o[4]   = comm_rx_full_i;
    ev_o[5]   = comm_tx_empty_i;
    ev_o[6]   = trace_trig_i;
  end
endmodule

// File: rtl/dbg_trig_out_stage.sv
module dbg_trig_out_stage
  import dbg_trig_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [NUM_OUT-1:0] wr_data_i,
  input  logic [NUM_OUT-1:0] req_i,
  input  logic               dbg_entry_i,
  input  logic               dbg_state_i,
  input  logic               pmu_irq_ni,
  input  logic [1:0]         perf_out_i,
  input  logic               comm_rx_full_i,
  input  logic               comm_tx_empty_i,
  input  logic               trace_trig_i,
  output logic [NUM_IN-1:0]  trig_in_o,
  output logic [NUM_OUT-2:0] trig_o,
  output logic               irq_no
);
  wr_sel_e              sel;
  logic [NUM_EDGE-1:0]  edge_en_q;
  logic                 compat_q;
  logic                 ack_halt, ack_irq, clr_halt;
  logic                 halt_q, irq_q;
  logic [NUM_EDGE-1:0]  edge_out;
  logic                 unused_wr_bits;

  assign sel            = wr_sel_e'(wr_sel_i);
  assign unused_wr_bits = ^wr_data_i[IRQ_IDX-1:NUM_EDGE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_en_q <= '0;
      compat_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (sel == SEL_EDGE) edge_en_q <= wr_data_i[NUM_EDGE-1:0];
      if (sel == SEL_MODE) compat_q  <= wr_data_i[0];
    end
  end

  // write-one-to-clear, not stored
  assign ack_halt = wr_en_i && (sel == SEL_ACK) && wr_data_i[HALT_IDX];
  assign ack_irq  = wr_en_i && (sel == SEL_ACK) && wr_data_i[IRQ_IDX];
  assign clr_halt = compat_q ? dbg_state_i : ack_halt;

  dbg_trig_sticky u_halt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_i[HALT_IDX]),
    .clr_i  (clr_halt),
    .q_o    (halt_q)
  );

  dbg_trig_sticky u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_i[IRQ_IDX]),
    .clr_i  (ack_irq),
    .q_o    (irq_q)
  );

  dbg_trig_edge #(.W(NUM_EDGE)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (edge_en_q),
    .req_i  (req_i[NUM_EDGE:1]),
    .out_o  (edge_out)
  );

  dbg_trig_in_cond u_in (
    .compat_i        (compat_q),
    .dbg_entry_i     (dbg_entry_i),
    .dbg_state_i     (dbg_state_i),
    .pmu_irq_ni      (pmu_irq_ni),
    .perf_out_i      (perf_out_i),
    .comm_rx_full_i  (comm_rx_full_i),
    .comm_tx_empty_i (comm_tx_empty_i),
    .trace_trig_i    (trace_trig_i),
    .ev_o            (trig_in_o)
  );

  assign trig_o = {req_i[RUN_IDX], edge_out, halt_q};
  assign irq_no = ~irq_q;

  AST_IRQ_REQ_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[IRQ_IDX] |=> !irq_no); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !(wr_en_i && wr_sel_i == 2'd1 && wr_data_i[IRQ_IDX])) |=> !irq_no); // R5
  AST_COMPAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (compat_q && dbg_state_i && !req_i[HALT_IDX]) |=> !trig_o[HALT_IDX]); // R8
  AST_COMPAT_ACK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (compat_q && trig_o[HALT_IDX] && !dbg_state_i) |=> trig_o[HALT_IDX]); // R8
endmodule

// File: tb/sim_dbg_trig_out_stage.sv
module sim_dbg_trig_out_stage;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [8:0] wr_data;
  logic [8:0] req;
  logic       dbg_entry, dbg_state, pmu_irq_n;
  logic [1:0] perf_out;
  logic       rx_full, tx_empty, trace_trig;
  logic [6:0] trig_in;
  logic [7:0] trig;
  logic       irq_n;

  int checks = 0;
  int failures = 0;

  logic       m_s0, m_s8, m_compat;
  logic [5:0] m_en, m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_trig_out_stage u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .req_i(req), .dbg_entry_i(dbg_entry),
    .dbg_state_i(dbg_state), .pmu_irq_ni(pmu_irq_n), .perf_out_i(perf_out),
    .comm_rx_full_i(rx_full), .comm_tx_empty_i(tx_empty),
    .trace_trig_i(trace_trig), .trig_in_o(trig_in), .trig_o(trig), .irq_no(irq_n)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [5:0] exp_edge();
    return (m_en & req[6:1] & ~m_prev) | (~m_en & req[6:1]);
  endfunction

  function automatic logic [6:0] exp_in();
    return {trace_trig, tx_empty, rx_full, perf_out, ~pmu_irq_n,
            m_compat ? dbg_state : dbg_entry};
  endfunction

  task automatic idle();
    wr_en = 0; wr_sel = 2'd3; wr_data = '0; req = '0;
    dbg_entry = 0; dbg_state = 0; pmu_irq_n = 1; perf_out = '0;
    rx_full = 0; tx_empty = 0; trace_trig = 0;
  endtask

  // called just after a negedge with inputs set; returns at next negedge
  task automatic step();
    logic ack, clr0;
    #1;
    check(m_compat ? "R8 halt" : "R4 halt", {15'd0, trig[0]}, {15'd0, m_s0});
    check("R7 irq", {15'd0, irq_n}, {15'd0, ~m_s8});
    check((m_en != 0) ? "R3 edge" : "R2 level", {8'd0, trig[7:1]}, {8'd0, req[7], exp_edge()});
    check("R9 in0", {15'd0, trig_in[0]}, {15'd0, exp_in()[0]});
    check("R10 in", {10'd0, trig_in[6:1]}, {10'd0, exp_in()[6:1]});
    @(posedge clk);
    ack  = wr_en && wr_sel == 2'd1;
    clr0 = m_compat ? dbg_state : (ack && wr_data[0]);
    m_s0 = req[0] | (m_s0 & ~clr0);
    m_s8 = req[8] | (m_s8 & ~(ack && wr_data[8]));
    m_prev = req[6:1];
    if (wr_en && wr_sel == 2'd0) m_en = wr_data[5:0];
    if (wr_en && wr_sel == 2'd2) m_compat = wr_data[0];
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [8:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    step();
    wr_en = 0; wr_sel = 2'd3; wr_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    rst_n = 0;
    m_s0 = 0; m_s8 = 0; m_compat = 0; m_en = '0; m_prev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 outs", {8'd0, trig}, 16'd0);
    check("R1 irq", {15'd0, irq_n}, 16'd1);
    @(negedge clk);

    // R1: edge enables cleared, held request stays level
    req[1] = 1; step(); step();
    check("R1 edge_off", {15'd0, trig[1]}, 16'd1);
    req = '0; step();

    // R3: enable edge on output 1 and 6
    wr(2'd0, 9'h021);
    req[1] = 1; req[6] = 1;
    #1 check("R3 pulse", {14'd0, trig[6], trig[1]}, 16'h3);
    step();
    #1 check("R3 once", {14'd0, trig[6], trig[1]}, 16'h0);
    step();
    req = '0; step();
    wr(2'd0, 9'h000);

    // R5: set irq, ack with zero sticky bits, then real ack
    req[8] = 1; step(); req = '0;
    wr(2'd1, 9'h0FE);
    #1 check("R5 zero_ack", {15'd0, irq_n}, 16'd0);
    wr(2'd1, 9'h100);
    #1 check("R5 ack", {15'd0, irq_n}, 16'd1);
    step();

    // R6: ack and new request together
    req[8] = 1; req[0] = 1; step(); req = '0;
    req[8] = 1; req[0] = 1; wr(2'd1, 9'h101); req = '0;
    #1 check("R6 req_wins", {14'd0, irq_n, trig[0]}, 16'h1);
    wr(2'd1, 9'h101);
    #1 check("R5 both_clr", {14'd0, irq_n, trig[0]}, 16'h2);

    // R8: compat mode
    wr(2'd2, 9'h001);
    req[0] = 1; req[8] = 1; step(); req = '0;
    wr(2'd1, 9'h001);
    #1 check("R8 ack_ignored", {15'd0, trig[0]}, 16'd1);
    dbg_state = 1; step(); dbg_state = 0;
    #1 check("R8 state_clr", {14'd0, irq_n, trig[0]}, 16'h0);
    dbg_state = 1; dbg_entry = 0;
    #1 check("R9 compat_in0", {15'd0, trig_in[0]}, 16'd1);
    step(); dbg_state = 0;
    wr(2'd1, 9'h100);
    wr(2'd2, 9'h000);
    dbg_entry = 1; dbg_state = 0;
    #1 check("R9 default_in0", {15'd0, trig_in[0]}, 16'd1);
    step(); idle();

    // random phase
    for (int i = 0; i < 600; i++) begin
      req[7:1]   = 7'($urandom);
      req[0]     = ($urandom % 12) == 0;
      req[8]     = ($urandom % 12) == 0;
      dbg_entry  = ($urandom % 8) == 0;
      dbg_state  = ($urandom % 4) == 0;
      pmu_irq_n  = 1'($urandom);
      perf_out   = 2'($urandom);
      rx_full    = 1'($urandom);
      tx_empty   = 1'($urandom);
      trace_trig = 1'($urandom);
      wr_en      = ($urandom % 6) == 0;
      wr_sel     = 2'($urandom);
      wr_data    = 9'($urandom);
      step();
    end
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule